// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

The block is an 8-bit up-counter fed by a system-clock prescaler. Software picks one of eight divide ratios. The counter runs in one of two modes. In interval mode, a wrap from 0xFF to 0x00 latches a flag and raises an interrupt request. In watchdog mode, the same wrap drives an external overflow pin and, when software has enabled it, an internal reset pulse. The reset pulse is either of power-on type or of manual type.

Software reaches three byte-wide registers over a small synchronous bus. Each access takes one cycle: select, write strobe, 2-bit address and 16-bit write word. Read data is combinational. Writes to the counter and to the control register carry a key in the upper byte of the word, so that a stray store cannot feed or reprogram the watchdog.

The pulse stage is a two-state machine.
- In `PULSE_IDLE` it waits for a watchdog-mode wrap. The transition *trigger* moves it to `PULSE_ACTIVE`, loads a length counter and latches the reset enable and reset type.
- In `PULSE_ACTIVE` it drives the outputs. The transition *expire* returns it to `PULSE_IDLE` once the length counter reaches zero.
- A wrap seen while the machine is in `PULSE_ACTIVE` does not restart the pulse.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the counter, control and reset-control registers all read 0x00, and `irq_o`, `wdt_ovf_o`, `rst_por_o` and `rst_man_o` are low.
- R2: Address 0 is the counter, address 1 the control register and address 2 the reset-control register. A write to the counter takes effect only if `bus_wdata[15:8]` is 0x5A, and a write to the control register only if it is 0xA5. Any other key leaves the register unchanged. The data byte is `bus_wdata[7:0]`.
- R3: The control register holds the flag in bit 7, the mode in bit 6 (1 = watchdog, 0 = interval), the enable in bit 5 and the clock select in bits 2:0. Bits 4:3 read as 0. Clock select values 0 to 7 give divide ratios of 4, 128, 256, 512, 1024, 2048, 8192 and 16384. With ratio N, the counter advances every N clocks, and the first increment lands N clocks after the edge that wrote enable = 1.
- R4: While enable is 0, the counter holds its value and the prescaler stays cleared.
- R5: In interval mode, a wrap from 0xFF to 0x00 sets control bit 7, and `irq_o` is high while that bit is set and the mode is interval. The overflow pin stays low.
- R6: Control bit 7 clears only on a keyed control write with data bit 7 = 0 that follows a read of the control register returning bit 7 = 1. The same write without such a read leaves the flag set. Software cannot set the flag.
- R7: In watchdog mode, a wrap raises `wdt_ovf_o` at that same clock edge. The pin stays high for exactly 128 clocks. The wrap sets reset-control bit 7, leaves control bit 7 unchanged, and keeps `irq_o` low.
- R8: Reset-control bit 6 enables the internal reset and bit 5 selects its type (0 = power-on, 1 = manual). When the reset is enabled, `rst_por_o` or `rst_man_o` is high for the same 128 clocks as the pin. When it is disabled, neither is raised.
- R9: Writes to the reset-control register need no key. Bits 6 and 5 take the written value. Bit 7 clears when written with 0 and is unaffected when written with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Key byte (15:8) and data byte (7:0) |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interval-mode interrupt request |
| wdt_ovf_o | output | 1 | Watchdog overflow pin |
| rst_por_o | output | 1 | Internal power-on reset pulse |
| rst_man_o | output | 1 | Internal manual reset pulse |

## Verification
Faults in the prescaler or the counter show up as a counter value off by one or more increments. That value can be read back in the first read after a timed run, and the overflow pin then rises a whole tick period early or late. A flag or arm bit in the wrong state appears at once on `irq_o` or in the next control read. A pulse machine stuck in `PULSE_ACTIVE`, or a length counter that is off, shows as a pin width other than 128 clocks within about 140 clocks of the wrap. A latched reset enable or type in the wrong state drives the wrong reset line during that same pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0] KEY_CNT  = 8'h5A;
    localparam logic [7:0] KEY_CTRL = 8'hA5;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_RST  = 2'd2;

    localparam int CTL_FLAG = 7;
    localparam int CTL_MODE = 6;
    localparam int CTL_EN   = 5;
    localparam int RST_FLAG = 7;
    localparam int RST_EN   = 6;
    localparam int RST_TYPE = 5;

    typedef enum logic {
        PULSE_IDLE   = 1'b0,
        PULSE_ACTIVE = 1'b1
    } pulse_state_e;

    // log2 of the divide ratio chosen by the 3-bit clock select
    function automatic int div_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 2;
            3'd1:    return 7;
            3'd2:    return 8;
            3'd3:    return 9;
            3'd4:    return 10;
            3'd5:    return 11;
            3'd6:    return 13;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int PSC_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            psc_q <= '0;
        else if (!run)
            psc_q <= '0;
        else
            psc_q <= psc_q + 1'b1;
    end

    always_comb begin
        mask = '0;
        for (int i = 0; i < PSC_W; i++)
            if (i < div_shift(sel))
                mask[i] = 1'b1;
    end

    assign tick = run && ((psc_q & mask) == mask);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = run && tick && !load && (cnt_q == '1);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic rst_en,
    input  logic rst_type,
    output logic pin_o,
    output logic por_o,
    output logic man_o
);
    localparam int LEN_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    pulse_state_e state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic             en_q;
    logic             type_q;

    // state register and the values latched on entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PULSE_IDLE;
            len_q   <= '0;
            en_q    <= 1'b0;
            type_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PULSE_IDLE && trig) begin
                len_q  <= LEN_W'(PULSE_LEN - 1);
                en_q   <= rst_en;
                type_q <= rst_type;
            end else if (state_q == PULSE_ACTIVE && len_q != '0) begin
                len_q <= len_q - 1'b1;
            end
        end
    end

    // transitions: trigger (IDLE->ACTIVE), expire (ACTIVE->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE:   if (trig) state_d = PULSE_ACTIVE;
            PULSE_ACTIVE: if (len_q == '0) state_d = PULSE_IDLE;
        endcase
    end

    always_comb begin
        pin_o = (state_q == PULSE_ACTIVE);
        por_o = pin_o && en_q && !type_q;
        man_o = pin_o && en_q && type_q;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PSC_W     = 14,
    parameter int PULSE_LEN = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [2*CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               irq_o,
    output logic               wdt_ovf_o,
    output logic               rst_por_o,
    output logic               rst_man_o
);
    logic [CNT_W-1:0] key_byte, data_byte;
    logic cnt_wr_ok, ctrl_wr_ok, rst_wr, ctrl_rd;
    logic flag_q, mode_q, en_q, armed_q;
    logic [2:0] sel_q;
    logic wovf_q, ren_q, rtype_q;
    logic tick, wrap;
    logic [CNT_W-1:0] cnt_q;

    assign key_byte  = bus_wdata[2*CNT_W-1:CNT_W];
    assign data_byte = bus_wdata[CNT_W-1:0];

    assign cnt_wr_ok  = bus_sel && bus_wr && bus_addr == ADDR_CNT  && key_byte == CNT_W'(KEY_CNT);
    assign ctrl_wr_ok = bus_sel && bus_wr && bus_addr == ADDR_CTRL && key_byte == CNT_W'(KEY_CTRL);
    assign rst_wr     = bus_sel && bus_wr && bus_addr == ADDR_RST;
    assign ctrl_rd    = bus_sel && !bus_wr && bus_addr == ADDR_CTRL;

    wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(en_q), .sel(sel_q), .tick(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick),
        .load(cnt_wr_ok), .load_val(data_byte), .cnt(cnt_q), .wrap(wrap)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(wrap && mode_q),
        .rst_en(ren_q), .rst_type(rtype_q),
        .pin_o(wdt_ovf_o), .por_o(rst_por_o), .man_o(rst_man_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            mode_q  <= 1'b0;
            en_q    <= 1'b0;
            sel_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (ctrl_wr_ok) begin
                mode_q <= data_byte[CTL_MODE];
                en_q   <= data_byte[CTL_EN];
                sel_q  <= data_byte[2:0];
            end
            if (wrap && !mode_q)
                flag_q <= 1'b1;
            else if (ctrl_wr_ok && armed_q && !data_byte[CTL_FLAG])
                flag_q <= 1'b0;
            if (ctrl_wr_ok)
                armed_q <= 1'b0;
            else if (ctrl_rd && flag_q)
                armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wovf_q  <= 1'b0;
            ren_q   <= 1'b0;
            rtype_q <= 1'b0;
        end else begin
            if (rst_wr) begin
                ren_q   <= data_byte[RST_EN];
                rtype_q <= data_byte[RST_TYPE];
            end
            if (wrap && mode_q)
                wovf_q <= 1'b1;
            else if (rst_wr && !data_byte[RST_FLAG])
                wovf_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CNT:  bus_rdata = cnt_q;
            ADDR_CTRL: begin
                bus_rdata[CTL_FLAG] = flag_q;
                bus_rdata[CTL_MODE] = mode_q;
                bus_rdata[CTL_EN]   = en_q;
                bus_rdata[2:0]      = sel_q;
            end
            ADDR_RST: begin
                bus_rdata[RST_FLAG] = wovf_q;
                bus_rdata[RST_EN]   = ren_q;
                bus_rdata[RST_TYPE] = rtype_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = flag_q && !mode_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             wdt_ovf_o,
    input logic             rst_por_o,
    input logic             rst_man_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             mode_q,
    input logic             en_q,
    input logic             cnt_wr_ok,
    input logic             ctrl_wr_ok
);
    logic [15:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_len <= '0;
        else if (wdt_ovf_o)
            hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1;
        else
            hi_len <= '0;
    end

    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr_ok) |=> $stable(cnt_q));

    a_r6_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(ctrl_wr_ok));

    a_r7_pin_starts_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_ovf_o) |-> ($past(cnt_q) == '1 && $past(mode_q) && $past(en_q)));

    a_r7_pin_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_ovf_o) |-> (hi_len == 16'(PULSE_LEN)));

    a_r8_one_reset_type: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_por_o && rst_man_o));

    a_r8_reset_inside_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_por_o || rst_man_o) |-> wdt_ovf_o);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o),
    .rst_por_o(rst_por_o), .rst_man_o(rst_man_o), .cnt_q(cnt_q),
    .mode_q(mode_q), .en_q(en_q), .cnt_wr_ok(cnt_wr_ok), .ctrl_wr_ok(ctrl_wr_ok)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o, wdt_ovf_o, rst_por_o, rst_man_o;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o), .rst_por_o(rst_por_o), .rst_man_o(rst_man_o)
    );

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: pushes the expected read value for the monitor
    task automatic bus_read(input logic [1:0] a, input logic [7:0] expv, input string tag);
        @(negedge clk);
        exp_q.push_back(expv); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        #1;
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, int'(bus_rdata), int'(e));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // timed run: enable at ratio sel, hold for span edges, disable, expect count
    task automatic timed_run(input logic [2:0] sel, input int span, input logic [7:0] start, input string tag);
        bus_write(2'd0, {8'h5A, start});
        bus_write(2'd1, {8'hA5, 8'h20 | {5'd0, sel}});
        repeat (span - 2) @(negedge clk);
        bus_write(2'd1, {8'hA5, {5'd0, sel}});
    endtask

    // watchdog run from 0xFE at /4: pin rises 8 edges after enabling
    task automatic wdt_run(input logic [7:0] rctl, input int exp_por, input int exp_man, input string tag);
        int n;
        bus_write(2'd2, {8'h00, rctl});
        bus_write(2'd0, {8'h5A, 8'hFE});
        bus_write(2'd1, {8'hA5, 8'h60});
        repeat (7) @(negedge clk);
        chk({tag, " pin low before wrap"}, int'(wdt_ovf_o), 0);
        @(negedge clk);
        chk({tag, " pin high at wrap"}, int'(wdt_ovf_o), 1);
        chk({tag, " por"}, int'(rst_por_o), exp_por);
        chk({tag, " man"}, int'(rst_man_o), exp_man);
        chk({tag, " no irq"}, int'(irq_o), 0);
        n = 1;
        while (wdt_ovf_o && n < 400) begin
            @(negedge clk);
            if (wdt_ovf_o) n++;
        end
        chk({tag, " pin width"}, n, 128);
        bus_write(2'd1, {8'hA5, 8'h40});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 pin", int'(wdt_ovf_o), 0);
        chk("R1 resets", int'(rst_por_o | rst_man_o), 0);
        bus_read(2'd0, 8'h00, "R1 counter");
        bus_read(2'd1, 8'h00, "R1 control");
        bus_read(2'd2, 8'h00, "R1 reset control");

        bus_write(2'd0, 16'h0037);
        bus_read(2'd0, 8'h00, "R2 counter wrong key");
        bus_write(2'd0, 16'hA537);
        bus_read(2'd0, 8'h00, "R2 counter control key");
        bus_write(2'd0, 16'h5A37);
        bus_read(2'd0, 8'h37, "R2 counter keyed");
        bus_write(2'd1, 16'h5A20);
        bus_read(2'd1, 8'h00, "R2 control wrong key");
        repeat (50) @(negedge clk);
        bus_read(2'd0, 8'h37, "R4 hold while disabled");

        timed_run(3'd0, 22, 8'h10, "R3");
        bus_read(2'd0, 8'h15, "R3 div4 five ticks");
        timed_run(3'd1, 3*128 + 5, 8'h10, "R3");
        bus_read(2'd0, 8'h13, "R3 div128 three ticks");
        timed_run(3'd7, 16383, 8'h20, "R3");
        bus_read(2'd0, 8'h20, "R3 div16384 one short");
        timed_run(3'd7, 16384, 8'h20, "R3");
        bus_read(2'd0, 8'h21, "R3 div16384 exact");
        bus_write(2'd1, 16'hA507);
        repeat (40) @(negedge clk);
        bus_read(2'd0, 8'h21, "R4 hold after disable");

        bus_write(2'd0, 16'h5AFE);
        bus_write(2'd1, 16'hA520);
        repeat (7) @(negedge clk);
        chk("R5 irq before wrap", int'(irq_o), 0);
        @(negedge clk);
        chk("R5 irq at wrap", int'(irq_o), 1);
        chk("R5 no pin in interval", int'(wdt_ovf_o), 0);
        bus_write(2'd1, 16'hA520);
        chk("R6 clear without read ignored", int'(irq_o), 1);
        bus_read(2'd1, 8'hA0, "R6 control with flag");
        bus_write(2'd1, 16'hA500);
        chk("R6 cleared after read", int'(irq_o), 0);
        bus_read(2'd1, 8'h00, "R6 control after clear");

        wdt_run(8'h40, 1, 0, "R8 power-on");
        bus_read(2'd2, 8'hC0, "R7 overflow flag set");
        bus_read(2'd1, 8'h40, "R7 control flag untouched");
        bus_write(2'd2, 16'h00C0);
        bus_read(2'd2, 8'hC0, "R9 write 1 keeps flag");
        bus_write(2'd2, 16'h0040);
        bus_read(2'd2, 8'h40, "R9 write 0 clears flag");
        wdt_run(8'h60, 0, 1, "R8 manual");
        wdt_run(8'h00, 0, 0, "R8 disabled");
        bus_read(2'd2, 8'h80, "R9 fields written directly");

        repeat (4) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule